// File: doc/BRIEF.md
# FIFO-Buffered Four-Phase Handshake Link

This block carries data words from a producer to a consumer over an internal request/acknowledge link. The link stands in for a direct wire. The producer offers at most one word per clock through a valid strobe and is never stalled. A sender controller places each word on the link, raises a request and waits for the acknowledge. A receiver controller captures the word, presents it downstream with a one-cycle valid pulse and raises the acknowledge. Both sides then return to low before the next word may start. One complete exchange therefore takes four clocks.

Words that arrive while the link is still busy wait in a finite FIFO on the sender side. When the FIFO is empty and the link is free, an arriving word skips the FIFO and goes straight onto the link. The only way a word can be lost is a FIFO overflow. Each such drop is flagged with a one-cycle pulse. The FIFO depth is a parameter, so it can be sized for the burst length that the producer is expected to reach.

Top module: `handshake_channel`

## Requirements
- R1: A synchronous active-high reset clears `outValid` and `overflow`, empties the FIFO and returns both controllers to idle. A word offered after reset is then delivered with the R2 latency.
- R2: With the FIFO empty and the link free, a word sampled at clock edge k appears on `outData` with `outValid` high in the cycle after edge k+1.
- R3: A word is captured exactly one clock edge after its request rises. The link data stays stable while the request is high. While words are waiting, successive `outValid` pulses are exactly 4 cycles apart.
- R4: The link follows a four-phase order: request rises only while acknowledge is low, request falls after acknowledge is seen, and acknowledge falls after request is seen low.
- R5: Words leave in exactly the order in which they were accepted.
- R6: A word that arrives while the FIFO holds DEPTH words, and no word leaves the FIFO in that cycle, is discarded. The stored words are kept, and `overflow` is high for exactly the one cycle after that arrival.
- R7: No word is lost except through R6. A stream of one word every 4 cycles or slower never raises `overflow`, and neither does a burst of DEPTH+2 consecutive words from an idle start.
- R8: A word that arrives while the FIFO is full, in the same cycle that a word leaves the FIFO for the link, is accepted and not flagged.
- R9: `outValid` is a single-cycle pulse for each delivered word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Producer offers a word this cycle |
| inData | input | WIDTH | Producer word |
| outValid | output | 1 | One-cycle pulse: `outData` holds a delivered word |
| outData | output | WIDTH | Delivered word |
| overflow | output | 1 | One-cycle pulse: the previous cycle's word was dropped |

## Verification
A lone word from an idle state fixes the bypass latency. A stream of one word every fourth cycle always meets the link just as it frees up, which shows that the direct path also works from the release phase and that no word is queued or flagged. Back-to-back bursts of DEPTH+2 and DEPTH+5 words separate queuing from loss. The longer burst drops exactly two words and then accepts the next word, because that word arrives in the same cycle as a FIFO pop. A reset in the middle of a burst shows that queued and in-flight words are discarded.

// File: rtl/hs_chan_pkg.sv
package hs_chan_pkg;

  // strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic push;        // write inData into the FIFO
    logic pop;         // move FIFO head into the link register
    logic loadDirect;  // move inData straight into the link register
    logic capture;     // receiver takes the link word
    logic drop;        // inData discarded, FIFO full
  } chanStrobes_t;

  typedef enum logic [1:0] {
    SND_IDLE,
    SND_REQ,
    SND_REL
  } sendState_t;

  typedef enum logic {
    RCV_IDLE,
    RCV_ACK
  } recvState_t;

endpackage

// File: rtl/hs_chan_datapath.sv
module hs_chan_datapath
  import hs_chan_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  chanStrobes_t     strb,
  input  logic [WIDTH-1:0] inData,
  output logic             fifoEmpty,
  output logic             fifoFull,
  output logic [WIDTH-1:0] linkData,
  output logic             outValid,
  output logic [WIDTH-1:0] outData,
  output logic             overflow
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == FULL_CNT);

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // link register: held stable for the whole request phase
  always_ff @(posedge clk) begin
    if (rst)                  linkData <= '0;
    else if (strb.loadDirect) linkData <= inData;
    else if (strb.pop)        linkData <= mem[rdPtr];
  end

  // receiver capture register and status pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      outData  <= '0;
      outValid <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (strb.capture) outData <= linkData;
      outValid <= strb.capture;
      overflow <= strb.drop;
    end
  end

  // R6
  dropOnlyWhenFull_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> $past(fifoFull));

  // R6
  noPushWhenFull_chk: assert property (@(posedge clk) disable iff (rst)
    strb.push |-> (!fifoFull || strb.pop));

  // R6
  countBound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R9
  outPulse_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

endmodule

// File: rtl/hs_chan_control.sv
module hs_chan_control
  import hs_chan_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         fifoEmpty,
  input  logic         fifoFull,
  output chanStrobes_t strb,
  output logic         req,
  output logic         ack
);

  sendState_t sndState;
  recvState_t rcvState;
  logic       linkReady;
  logic       startXfer;

  assign req = (sndState == SND_REQ);
  assign ack = (rcvState == RCV_ACK);

  // link free: idle, or release phase with acknowledge already low
  assign linkReady = (sndState == SND_IDLE) || ((sndState == SND_REL) && !ack);

  always_comb begin
    strb            = '0;
    strb.loadDirect = inValid && linkReady && fifoEmpty;
    strb.pop        = linkReady && !fifoEmpty;
    strb.push       = inValid && !strb.loadDirect && (!fifoFull || strb.pop);
    strb.drop       = inValid && !strb.loadDirect && fifoFull && !strb.pop;
    strb.capture    = (rcvState == RCV_IDLE) && req;
  end

  assign startXfer = strb.loadDirect || strb.pop;

  // sender controller
  always_ff @(posedge clk) begin
    if (rst) begin
      sndState <= SND_IDLE;
    end else begin
      unique case (sndState)
        SND_IDLE: if (startXfer) sndState <= SND_REQ;
        SND_REQ:  if (ack)       sndState <= SND_REL;
        SND_REL:  if (!ack)      sndState <= startXfer ? SND_REQ : SND_IDLE;
        default:                 sndState <= SND_IDLE;
      endcase
    end
  end

  // receiver controller
  always_ff @(posedge clk) begin
    if (rst) begin
      rcvState <= RCV_IDLE;
    end else begin
      unique case (rcvState)
        RCV_IDLE: if (req)  rcvState <= RCV_ACK;
        RCV_ACK:  if (!req) rcvState <= RCV_IDLE;
        default:            rcvState <= RCV_IDLE;
      endcase
    end
  end

  // R4
  reqRiseAckLow_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> !ack);

  // R4
  reqDropAfterAck_chk: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> !req);

  // R4
  ackDropAfterReq_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !req) |=> !ack);

  // R6
  dropExclusive_chk: assert property (@(posedge clk) disable iff (rst)
    strb.drop |-> !(strb.push || strb.loadDirect));

endmodule

// File: rtl/handshake_channel.sv
module handshake_channel
  import hs_chan_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [WIDTH-1:0] inData,
  output logic             outValid,
  output logic [WIDTH-1:0] outData,
  output logic             overflow
);

  chanStrobes_t     strb;
  logic             fifoEmpty, fifoFull;
  logic             req, ack;
  logic [WIDTH-1:0] linkData;

  hs_chan_control i_control (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .strb      (strb),
    .req       (req),
    .ack       (ack)
  );

  hs_chan_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .inData    (inData),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .linkData  (linkData),
    .outValid  (outValid),
    .outData   (outData),
    .overflow  (overflow)
  );

  // R3
  linkStable_chk: assert property (@(posedge clk) disable iff (rst)
    (req && $past(req)) |-> $stable(linkData));

  // R3
  captureAfterReq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |=> (outValid && ack));

  // R4
  ackNeedsReq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> req);

endmodule

// File: tb/test_handshake_channel.sv
`timescale 1ns/100ps
module test_handshake_channel;

  localparam int WIDTH = 16;
  localparam int DEPTH = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inValid = 1'b0;
  logic [WIDTH-1:0] inData = '0;
  logic             outValid;
  logic [WIDTH-1:0] outData;
  logic             overflow;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int lastOut = -1;
  bit spacingOn = 1'b0;
  bit prevDrop  = 1'b0;
  bit finished  = 1'b0;
  logic [WIDTH-1:0] expQ [$];

  always #2.5 clk = ~clk;

  handshake_channel #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_handshake_channel (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData),
    .overflow (overflow)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver: one cycle per call, checks overflow for the word of the previous cycle
  task automatic step(input logic v, input logic [WIDTH-1:0] d, input bit drop);
    @(negedge clk);
    check(overflow == prevDrop, prevDrop ? "R6 overflow pulse" : "R7 no spurious overflow",
          int'(overflow), int'(prevDrop));
    inValid  = v;
    inData   = d;
    prevDrop = v && drop;
    if (v && !drop) expQ.push_back(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0);
  endtask

  // R2 / R1: lone word from idle, empty state
  task automatic loneWord(input logic [WIDTH-1:0] d, input string tag);
    step(1'b1, d, 1'b0);
    step(1'b0, '0, 1'b0);
    check(outValid == 1'b0, tag, int'(outValid), 0);
    step(1'b0, '0, 1'b0);
    check(outValid == 1'b1, tag, int'(outValid), 1);
    check(outData == d, tag, int'(outData), int'(d));
  endtask

  // monitor: scoreboard compare (R5), spacing (R3), pulse width (R9)
  bit prevOutValid = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected word", int'(outData), 0);
        end else begin
          logic [WIDTH-1:0] e;
          e = expQ.pop_front();
          check(outData == e, "R5 order", int'(outData), int'(e));
        end
        if (spacingOn && lastOut >= 0)
          check(cyc - lastOut == 4, "R3 spacing", cyc - lastOut, 4);
        lastOut = cyc;
      end
      if (prevOutValid && outValid)
        check(1'b0, "R9 pulse width", 1, 0);
    end
    prevOutValid = outValid;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1 outValid", int'(outValid), 0);
    check(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
    rst = 1'b0;
    idle(3);

    // R2: bypass latency
    loneWord(16'h1234, "R2 latency");
    idle(8);

    // R7 / R3: one word every 4 cycles, direct path from release phase
    spacingOn = 1'b1; lastOut = -1;
    for (int i = 0; i < 10; i++) begin
      step(1'b1, 16'hA000 + 16'(i), 1'b0);
      idle(3);
    end
    idle(10);
    spacingOn = 1'b0;

    // R7 / R3: burst of DEPTH+2 with no loss
    spacingOn = 1'b1; lastOut = -1;
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 16'hB000 + 16'(i), 1'b0);
    idle(40);
    spacingOn = 1'b0;

    // R6 / R8: burst of 9 with DEPTH 4: words 6 and 7 dropped,
    // word 8 meets a FIFO pop and is accepted
    spacingOn = 1'b1; lastOut = -1;
    for (int i = 0; i < 9; i++)
      step(1'b1, 16'hC000 + 16'(i), (i == 6) || (i == 7));
    idle(50);
    spacingOn = 1'b0;
    check(expQ.size() == 0, "R7 all delivered", expQ.size(), 0);

    // R1: reset in the middle of a burst discards queued words
    for (int i = 0; i < 5; i++) step(1'b1, 16'hD000 + 16'(i), 1'b0);
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; prevDrop = 1'b0;
    expQ.delete();
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 reset outValid", int'(outValid), 0);
    rst = 1'b0;
    idle(2);
    loneWord(16'h5A5A, "R1 empty after reset");
    idle(20);
    check(expQ.size() == 0, "R5 queue drained", expQ.size(), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule